// File: doc/BRIEF.md
# FIFO Read-Side Timing-Mode Controller

This block is the output half of a single-clock FIFO. It picks one of two read timings at master reset. In the first, called standard mode, every word needs an explicit read to reach the output register, including the first word after the FIFO was empty. In the second, called fall-through mode, the oldest stored word moves into the output register by itself, and a read only retires the word already on display. The two status outputs change meaning with the mode.

Storage is a plain register array with write and read pointers and an occupancy count. A read select input, sampled on the clock, gates every read. The same select, delayed by one edge, together with an asynchronous output enable, decides whether the data bus is driven or left high-impedance. Depth expansion and clock-domain crossing are left to the surrounding logic.

Top module: `fifo_rd_mode_ctrl`

## Requirements
- R1: The mode is loaded from `fwft_i` at each rising clock edge while `rst_ni` is low: 0 selects standard mode, 1 selects fall-through mode. Changes on `fwft_i` after reset is released have no effect.
- R2: In standard mode, the output register holds zero after reset. A write alone never changes it. A read (`rd_en_i` and `rd_sel_i` high at a rising edge, with stored data) loads the oldest word, and that word is visible after that edge.
- R3: In standard mode, `out_flag_o` is the empty flag: 1 when no words are stored. `in_flag_o` is the full flag: 1 when DEPTH words are stored. A write while full is dropped.
- R4: In fall-through mode, a word written into an empty FIFO at one edge reaches `rd_data_o` at the next rising edge, with `out_flag_o` going to 1, without any read.
- R5: In fall-through mode, while a word is on display, the data and `out_flag_o` stay unchanged until a read. Each read replaces the word with the next stored one, in write order.
- R6: In fall-through mode, `out_flag_o` is output-ready (1 means a valid word is displayed) and `in_flag_o` is input-ready. Input-ready is 0 only when the array holds DEPTH words, so the FIFO takes DEPTH+1 words counting the displayed one.
- R7: In fall-through mode, reading the displayed word while the array is empty clears output-ready after that edge.
- R8: A read while empty (standard mode) or while output-ready is 0 (fall-through mode) changes nothing. The next written word is still the next one delivered.
- R9: A read with `rd_sel_i` low at the edge is ignored. The output word and the stored data are unchanged.
- R10: `rd_bus_en_o` is 1 exactly when `oe_i` is 1 and `rd_sel_i` was 1 at the previous rising edge. `oe_i` acts at once, without a clock. `rd_data_o` is high-impedance whenever `rd_bus_en_o` is 0.
- R11: Master reset clears all stored data. After reset, standard mode shows empty=1 and full=0, and fall-through mode shows output-ready=0 and input-ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the read and write sides |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| fwft_i | input | 1 | Mode select, loaded while in reset (1 = fall-through) |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 1 | Read select; gates reads and, one edge later, the bus drive |
| oe_i | input | 1 | Asynchronous output enable |
| rd_data_o | output | WIDTH | Output register, high-impedance when not driven |
| rd_bus_en_o | output | 1 | 1 while `rd_data_o` is driven |
| out_flag_o | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |
| in_flag_o | output | 1 | Full (standard mode) or input-ready (fall-through mode) |

## Verification
The assertions assume that `rst_ni` stays low for at least one rising edge, so the mode register is loaded before any property is enabled. They also assume that `fwft_i` needs no particular value after release. The bench holds reset for three edges and then drives `fwft_i` to the opposite value, so a mode that leaked from the live pin would be seen. All inputs change on the falling edge, and the data bus is read only while `rd_bus_en_o` is 1, since its value is undefined when high-impedance.

// File: rtl/fifo_rd_pkg.sv
package fifo_rd_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign head_o  = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_i)   rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + {{(CW-1){1'b0}}, push_ok} - {{(CW-1){1'b0}}, pop_i};
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/rd_out_stage.sv
module rd_out_stage
  import fifo_rd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rd_mode_e         mode_i,
  input  logic             rd_en_i,
  input  logic             sel_i,
  input  logic             mem_empty_i,
  input  logic [WIDTH-1:0] mem_head_i,
  output logic             pop_o,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] data_q;
  logic             valid_q;
  logic             req, fire;

  assign req  = rd_en_i && sel_i;
  // fall-through retires the displayed word; standard pulls straight from memory
  assign fire = req && valid_q;

  always_comb begin
    if (mode_i == MODE_FWFT) pop_o = !mem_empty_i && (!valid_q || fire);
    else                     pop_o = req && !mem_empty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop_o) data_q <= mem_head_i;
      if (mode_i == MODE_FWFT) begin
        if (pop_o)     valid_q <= 1'b1;
        else if (fire) valid_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  a_r4_fall_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && !valid_q && !mem_empty_i) |=> valid_q);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && valid_q && !req) |=> (valid_q && $stable(data_q)));
  a_r7_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && fire && mem_empty_i) |=> !valid_q);
  a_r9_sel_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STD && !sel_i) |=> $stable(data_q));
endmodule

// File: rtl/rd_flag_sel.sv
module rd_flag_sel
  import fifo_rd_pkg::*;
(
  input  rd_mode_e mode_i,
  input  logic     valid_i,
  input  logic     mem_empty_i,
  input  logic     mem_full_i,
  output logic     out_flag_o,
  output logic     in_flag_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FWFT: begin
        out_flag_o = valid_i;
        in_flag_o  = !mem_full_i;
      end
      default: begin
        out_flag_o = mem_empty_i;
        in_flag_o  = mem_full_i;
      end
    endcase
  end
endmodule

// File: rtl/fifo_rd_mode_ctrl.sv
module fifo_rd_mode_ctrl
  import fifo_rd_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fwft_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_bus_en_o,
  output logic             out_flag_o,
  output logic             in_flag_o
);
  rd_mode_e         mode_q;
  logic             sel_q;
  logic             pop, mem_empty, mem_full, valid;
  logic [WIDTH-1:0] head, out_data;

  // mode is loaded only while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= rd_mode_e'(fwft_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= rd_sel_i;
  end

  fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_en_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (mem_empty),
    .full_o      (mem_full)
  );

  rd_out_stage #(.WIDTH(WIDTH)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .rd_en_i     (rd_en_i),
    .sel_i       (rd_sel_i),
    .mem_empty_i (mem_empty),
    .mem_head_i  (head),
    .pop_o       (pop),
    .data_o      (out_data),
    .valid_o     (valid)
  );

  rd_flag_sel u_flags (
    .mode_i      (mode_q),
    .valid_i     (valid),
    .mem_empty_i (mem_empty),
    .mem_full_i  (mem_full),
    .out_flag_o  (out_flag_o),
    .in_flag_o   (in_flag_o)
  );

  assign rd_bus_en_o = sel_q && oe_i;
  assign rd_data_o   = rd_bus_en_o ? out_data : 'z;

  a_r1_mode_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(mode_q));
  a_r10_bus_after_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bus_en_o |-> $past(rd_sel_i));
endmodule

// File: tb/fifo_rd_mode_ctrl_tb.sv
module fifo_rd_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_ni, fwft_i, wr_en_i, rd_en_i, rd_sel_i, oe_i;
  logic [W-1:0] wr_data_i;
  wire  [W-1:0] rd_data_o;
  logic         rd_bus_en_o, out_flag_o, in_flag_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  fifo_rd_mode_ctrl #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i), .oe_i(oe_i),
    .rd_data_o(rd_data_o), .rd_bus_en_o(rd_bus_en_o),
    .out_flag_o(out_flag_o), .in_flag_o(in_flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    rst_ni = 1'b0; fwft_i = mode; wr_en_i = 1'b0; rd_en_i = 1'b0;
    rd_sel_i = 1'b1; oe_i = 1'b1; wr_data_i = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    fwft_i = ~mode;
  endtask

  task automatic push(input logic [W-1:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pull();
    rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
  endtask

  task automatic test_std();
    do_reset(1'b0);
    chk("R11 empty after reset", out_flag_o, 1);
    chk("R11 full after reset", in_flag_o, 0);
    tick();
    chk("R10 bus driven", rd_bus_en_o, 1);
    chk("R2 reset output", rd_data_o, 0);
    push(16'h1111);
    chk("R3 not empty", out_flag_o, 0);
    tick();
    chk("R1 R2 no fall-through in standard", rd_data_o, 0);
    pull();
    chk("R2 read loads word", rd_data_o, 16'h1111);
    chk("R3 empty again", out_flag_o, 1);
    pull();
    chk("R8 read while empty", rd_data_o, 16'h1111);
    push(16'h2222);
    pull();
    chk("R8 pointers intact", rd_data_o, 16'h2222);
    for (int i = 0; i < D; i++) push(W'(16'h0100 + i));
    chk("R3 full", in_flag_o, 1);
    push(16'hEEEE);
    for (int i = 0; i < D; i++) begin
      pull();
      chk("R3 order", rd_data_o, 16'h0100 + i);
    end
    chk("R3 write while full dropped", out_flag_o, 1);
    pull();
    chk("R3 R8 no extra word", rd_data_o, 16'h0100 + D - 1);
  endtask

  task automatic test_std_sel();
    push(16'h3333);
    rd_sel_i = 1'b0; rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
    chk("R10 bus off after deselect", rd_bus_en_o, 0);
    rd_sel_i = 1'b1;
    tick();
    chk("R9 deselected read ignored", rd_data_o, 16'h0100 + D - 1);
    chk("R9 word still stored", out_flag_o, 0);
    oe_i = 1'b0;
    #1;
    chk("R10 oe off immediately", rd_bus_en_o, 0);
    oe_i = 1'b1;
    #1;
    chk("R10 oe on immediately", rd_bus_en_o, 1);
    pull();
    chk("R9 word delivered later", rd_data_o, 16'h3333);
  endtask

  task automatic test_fwft();
    do_reset(1'b1);
    chk("R11 not ready after reset", out_flag_o, 0);
    chk("R11 input ready after reset", in_flag_o, 1);
    tick();
    push(16'h00A1);
    chk("R4 not yet ready", out_flag_o, 0);
    tick();
    chk("R1 R4 ready without read", out_flag_o, 1);
    chk("R4 first word", rd_data_o, 16'h00A1);
    push(16'h00B2);
    push(16'h00C3);
    tick();
    chk("R5 held without read", rd_data_o, 16'h00A1);
    chk("R5 still ready", out_flag_o, 1);
    pull();
    chk("R5 advance 1", rd_data_o, 16'h00B2);
    pull();
    chk("R5 advance 2", rd_data_o, 16'h00C3);
    chk("R7 ready while word shown", out_flag_o, 1);
    pull();
    chk("R7 ready cleared", out_flag_o, 0);
    pull();
    push(16'h00D4);
    tick();
    chk("R8 next word after idle read", rd_data_o, 16'h00D4);
    chk("R8 ready", out_flag_o, 1);
    pull();
    chk("R7 cleared again", out_flag_o, 0);
    for (int i = 0; i < D; i++) push(W'(16'h0200 + i));
    chk("R6 input ready below capacity", in_flag_o, 1);
    push(W'(16'h0200 + D));
    chk("R6 input ready low at capacity", in_flag_o, 0);
    push(16'hEEEE);
    for (int i = 0; i <= D; i++) begin
      chk("R6 fill order", rd_data_o, 16'h0200 + i);
      pull();
    end
    chk("R6 drained, extra dropped", out_flag_o, 0);
    chk("R6 input ready restored", in_flag_o, 1);
  endtask

  task automatic test_fwft_sel();
    push(16'h00E5);
    tick();
    chk("R4 shown", rd_data_o, 16'h00E5);
    push(16'h00F6);
    rd_sel_i = 1'b0; rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0; rd_sel_i = 1'b1;
    tick();
    chk("R9 fall-through read ignored", rd_data_o, 16'h00E5);
    pull();
    chk("R9 next word after select", rd_data_o, 16'h00F6);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    test_std();
    test_std_sel();
    test_fwft();
    test_fwft_sel();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule